// File: doc/BRIEF.md
# Sleep Interval Power Sequencer

This block moves a MAC device into a low-power state and brings it back out. It runs on the fast system clock and samples a slow 32.768 kHz timebase. Each rising edge of the slow input, once synchronised, is one slow tick. All interval counting and timestamping is done in slow ticks. The host asks for power-down by writing a request bit. That write raises an interrupt to the embedded controller. The controller then issues a sleep command.

While asleep, the fast clock-enable is low. After a programmable sleep length, the block enters a warm-up interval. In warm-up the fast clock is running again, but the device is not yet considered awake. When warm-up ends, the block returns to the awake state and posts a wake interrupt. A disable bit prevents entry. A rising edge on the disable bit ends a sleep or warm-up within a few fast clocks.

A free-running timestamp counter advances on every slow tick. Only the hard reset clears it. A synchronous soft reset returns the sequencer and its status to idle but leaves the timestamp running. A restriction flag tells the surrounding bus logic that only a small register window may be accessed while powered down.

Top module: `slpseq_top`

## Requirements
- R1: When the block is awake and the disable bit is 0, a one-cycle sleep command sets `pd_flag` to 1 and `fast_clk_en` to 0 in the cycle after the command.
- R2: The sleep length L is `{len_hi[6:0], len_mid[7:0], len_lo[7:0]}` (23 bits). The block stays asleep, with `fast_clk_en` at 0, for exactly L slow rising edges after the command. L = 0 behaves as L = 1.
- R3: After the sleep length, `fast_clk_en` returns to 1 while `pd_flag` stays 1 for exactly W further slow rising edges, where W = `warm_len` (4 bits). Then `pd_flag` drops to 0 and `ec_status[4]` (wake done) is set.
- R4: While `dis_pd` is 1, a sleep command is ignored and `pd_flag` stays 0.
- R5: A 0-to-1 change of `dis_pd` during sleep or warm-up returns `pd_flag` to 0 and `fast_clk_en` to 1 within three fast clocks. This forced exit does not set `ec_status[4]`.
- R6: `ts_count` increments by one on every slow rising edge in every state. Only `rst_n` clears it.
- R7: A `host_req_wr` pulse sets `ec_status[5]`. `ec_irq` is 1 whenever any status bit is 1. A 1 in `ec_ack` clears the matching status bit.
- R8: `reg_lock` equals `pd_flag` when `restrict_mode` is 1, and is 0 when `restrict_mode` is 0.
- R9: `soft_rst` returns the block to the awake state and clears `ec_status`. It leaves `ts_count` unchanged apart from normal counting.
- R10: After `rst_n`, the outputs are as follows: `pd_flag` = 0, `fast_clk_en` = 1, `ec_status` = 0, `ec_irq` = 0 and `ts_count` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Hard reset, synchronous, active low |
| soft_rst | input | 1 | Soft reset, synchronous, active high |
| slow_clk_in | input | 1 | 32.768 kHz timebase, asynchronous |
| len_lo | input | 8 | Sleep length bits 7..0 |
| len_mid | input | 8 | Sleep length bits 15..8 |
| len_hi | input | 7 | Sleep length bits 22..16 |
| warm_len | input | 4 | Warm-up length in slow ticks |
| dis_pd | input | 1 | Power-down disable bit |
| host_req_wr | input | 1 | Host writes 1 to the power-down request bit |
| sleep_cmd | input | 1 | Controller command to enter sleep |
| ec_ack | input | 8 | Write-one-to-clear for status bits |
| restrict_mode | input | 1 | Bus mode in which access is restricted while powered down |
| pd_flag | output | 1 | Device powered down (sleep or warm-up) |
| fast_clk_en | output | 1 | Fast domain clock enable |
| reg_lock | output | 1 | Only the low register window may be accessed |
| ec_status | output | 8 | Status: bit 5 request pending, bit 4 wake done |
| ec_irq | output | 1 | Interrupt to embedded controller |
| ts_count | output | 24 | Free-running slow-tick timestamp |

## Verification
The sleep sequence is run with several length and warm-up pairs:
- zero length and zero warm-up, which separates L = 0 from an instant wake;
- unit and small lengths, which expose an off-by-one in either count;
- a length that uses the middle byte field, which shows that the fields are concatenated correctly;
- the largest warm-up value.

Each run counts slow rising edges from the command to the return of the clock enable, and from there to the end of warm-up.

The disable bit is exercised twice: once held before a command, which shows that entry is blocked, and once raised mid-sleep, which shows the timed forced exit. Timestamp deltas are compared with counted edges across a sleep, a soft reset and a hard reset. This shows that only the hard reset clears the timestamp.

// File: rtl/slpseq_pkg.sv
// Shared types for the sleep interval power sequencer.
// Assumes: the three states are encoded in two bits.
package slpseq_pkg;

    typedef enum logic [1:0] {
        ST_AWAKE = 2'd0,
        ST_SLEEP = 2'd1,
        ST_WARM  = 2'd2
    } pwr_state_e;

    localparam int STAT_W      = 8;
    localparam int STAT_REQ    = 5;
    localparam int STAT_WAKE   = 4;

endpackage

// File: rtl/slpseq_tick.sv
// Synchronises the slow timebase into the fast domain and emits a
// one-cycle tick per slow rising edge.
// Assumes: the slow input stays stable for at least two fast clocks.
module slpseq_tick (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_in,
    output logic tick
);
    logic [2:0] sh;

    // Two synchroniser flops plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[1:0], slow_in};
    end

    assign tick = sh[1] & ~sh[2];
endmodule

// File: rtl/slpseq_stamp.sv
// Free-running timestamp of slow ticks.
// Assumes: only the hard reset clears it; soft resets are not wired here.
module slpseq_stamp #(
    parameter int TS_W = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    output logic [TS_W-1:0] ts
);
    // Count every slow tick, wrapping at the counter width.
    always_ff @(posedge clk) begin
        if (!rst_n)    ts <= '0;
        else if (tick) ts <= ts + 1'b1;
    end
endmodule

// File: rtl/slpseq_fsm.sv
// Power state machine with sleep-length and warm-up counters.
// Assumes: tick is a one-cycle pulse; sleep_cmd is a one-cycle pulse.
module slpseq_fsm
    import slpseq_pkg::*;
#(
    parameter int LEN_W  = 23,
    parameter int WARM_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              tick,
    input  logic              sleep_cmd,
    input  logic              dis_pd,
    input  logic [LEN_W-1:0]  len_val,
    input  logic [WARM_W-1:0] warm_val,
    output pwr_state_e        state,
    output logic              wake_evt
);
    logic [LEN_W-1:0]  len_cnt;
    logic [WARM_W-1:0] warm_cnt;
    logic              dis_q;
    logic              dis_rise;

    assign dis_rise = dis_pd & ~dis_q;

    // Remember the previous disable level for rise detection.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) dis_q <= 1'b0;
        else                    dis_q <= dis_pd;
    end

    // State transitions and interval counting.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            state    <= ST_AWAKE;
            len_cnt  <= '0;
            warm_cnt <= '0;
            wake_evt <= 1'b0;
        end else begin
            wake_evt <= 1'b0;
            unique case (state)
                ST_AWAKE: begin
                    if (sleep_cmd && !dis_pd) begin
                        state   <= ST_SLEEP;
                        len_cnt <= len_val;
                    end
                end
                ST_SLEEP: begin
                    if (dis_rise) begin
                        state <= ST_AWAKE;
                    end else if (tick) begin
                        if (len_cnt <= LEN_W'(1)) begin
                            state    <= ST_WARM;
                            warm_cnt <= warm_val;
                        end else begin
                            len_cnt <= len_cnt - 1'b1;
                        end
                    end
                end
                ST_WARM: begin
                    if (dis_rise) begin
                        state <= ST_AWAKE;
                    end else if (warm_cnt == '0) begin
                        state    <= ST_AWAKE;
                        wake_evt <= 1'b1;
                    end else if (tick) begin
                        warm_cnt <= warm_cnt - 1'b1;
                    end
                end
                default: state <= ST_AWAKE;
            endcase
        end
    end
endmodule

// File: rtl/slpseq_irq.sv
// Interrupt status toward the embedded controller, write-one-to-clear.
// Assumes: a set event and a clear in the same cycle leave the bit set.
module slpseq_irq
    import slpseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              req_set,
    input  logic              wake_set,
    input  logic [STAT_W-1:0] ack,
    output logic [STAT_W-1:0] status,
    output logic              irq
);
    logic [STAT_W-1:0] set_vec;

    // Place each event at its status bit position.
    always_comb begin
        set_vec            = '0;
        set_vec[STAT_REQ]  = req_set;
        set_vec[STAT_WAKE] = wake_set;
    end

    // Sticky status bits with acknowledge clear.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) status <= '0;
        else                    status <= (status & ~ack) | set_vec;
    end

    assign irq = |status;
endmodule

// File: rtl/slpseq_top.sv
// Sleep interval power sequencer top level.
// Assumes: all register-field inputs are already in the fast domain;
// only slow_clk_in is asynchronous.
module slpseq_top
    import slpseq_pkg::*;
#(
    parameter int LEN_W  = 23,
    parameter int WARM_W = 4,
    parameter int TS_W   = 24,
    localparam int HI_W  = LEN_W - 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              slow_clk_in,
    input  logic [7:0]        len_lo,
    input  logic [7:0]        len_mid,
    input  logic [HI_W-1:0]   len_hi,
    input  logic [WARM_W-1:0] warm_len,
    input  logic              dis_pd,
    input  logic              host_req_wr,
    input  logic              sleep_cmd,
    input  logic [STAT_W-1:0] ec_ack,
    input  logic              restrict_mode,
    output logic              pd_flag,
    output logic              fast_clk_en,
    output logic              reg_lock,
    output logic [STAT_W-1:0] ec_status,
    output logic              ec_irq,
    output logic [TS_W-1:0]   ts_count
);
    logic       tick;
    logic       wake_evt;
    pwr_state_e state;

    slpseq_tick u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .slow_in (slow_clk_in),
        .tick    (tick)
    );

    slpseq_stamp #(.TS_W(TS_W)) u_stamp (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .ts    (ts_count)
    );

    slpseq_fsm #(.LEN_W(LEN_W), .WARM_W(WARM_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .tick      (tick),
        .sleep_cmd (sleep_cmd),
        .dis_pd    (dis_pd),
        .len_val   ({len_hi, len_mid, len_lo}),
        .warm_val  (warm_len),
        .state     (state),
        .wake_evt  (wake_evt)
    );

    slpseq_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .req_set  (host_req_wr),
        .wake_set (wake_evt),
        .ack      (ec_ack),
        .status   (ec_status),
        .irq      (ec_irq)
    );

    assign pd_flag     = (state != ST_AWAKE);
    assign fast_clk_en = (state != ST_SLEEP);
    assign reg_lock    = pd_flag & restrict_mode;
endmodule

// File: rtl/slpseq_chk.sv
// Assertion checker for slpseq_top, attached with bind below.
// Assumes: rst_n is held for at least two clocks at start.
module slpseq_chk #(
    parameter int TS_W = 24
) (
    input logic            clk,
    input logic            rst_n,
    input logic            soft_rst,
    input logic            dis_pd,
    input logic            host_req_wr,
    input logic            pd_flag,
    input logic            fast_clk_en,
    input logic            reg_lock,
    input logic [7:0]      ec_status,
    input logic [TS_W-1:0] ts_count
);
    // R4: no entry while disabled.
    p_no_entry_r4: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (dis_pd && !pd_flag) |=> !pd_flag);

    // R5: disable rise ends power-down within the allowed window.
    p_fast_exit_r5: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        ($rose(dis_pd) && pd_flag) |-> ##2 !pd_flag);

    // R3: a stopped fast clock implies power-down.
    p_clk_off_pd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !fast_clk_en |-> pd_flag);

    // R6: timestamp holds or steps by one.
    p_ts_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_count == $past(ts_count)) || (ts_count == $past(ts_count) + 1'b1));

    // R8: restriction only while powered down.
    p_lock_pd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_lock |-> pd_flag);

    // R7: host request shows up in status bit 5.
    p_req_stat_r7: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        host_req_wr |=> ec_status[5]);
endmodule

bind slpseq_top slpseq_chk #(.TS_W(TS_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .dis_pd      (dis_pd),
    .host_req_wr (host_req_wr),
    .pd_flag     (pd_flag),
    .fast_clk_en (fast_clk_en),
    .reg_lock    (reg_lock),
    .ec_status   (ec_status),
    .ts_count    (ts_count)
);

// File: tb/slpseq_top_test.sv
module slpseq_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int SLOW_HALF  = 10;
    localparam int WD_LIMIT   = 150000;
    localparam int NVEC       = 6;
    // Each entry: {length[22:0], warm[3:0]}
    localparam logic [26:0] VEC [NVEC] = '{
        {23'd0,     4'd0},
        {23'd1,     4'd2},
        {23'd3,     4'd0},
        {23'd5,     4'd4},
        {23'h000102, 4'd1},
        {23'd2,     4'd15}
    };

    logic        clk = 0;
    logic        rst_n = 0;
    logic        soft_rst = 0;
    logic        slow = 0;
    logic [7:0]  len_lo = 0, len_mid = 0;
    logic [6:0]  len_hi = 0;
    logic [3:0]  warm_len = 0;
    logic        dis_pd = 0, host_req_wr = 0, sleep_cmd = 0, restrict_mode = 0;
    logic [7:0]  ec_ack = 0;
    logic        pd_flag, fast_clk_en, reg_lock, ec_irq;
    logic [7:0]  ec_status;
    logic [23:0] ts_count;

    int total = 0, bad = 0, rises = 0, cyc = 0;
    bit timed_out = 0;

    slpseq_top uut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .slow_clk_in(slow),
        .len_lo(len_lo), .len_mid(len_mid), .len_hi(len_hi), .warm_len(warm_len),
        .dis_pd(dis_pd), .host_req_wr(host_req_wr), .sleep_cmd(sleep_cmd),
        .ec_ack(ec_ack), .restrict_mode(restrict_mode),
        .pd_flag(pd_flag), .fast_clk_en(fast_clk_en), .reg_lock(reg_lock),
        .ec_status(ec_status), .ec_irq(ec_irq), .ts_count(ts_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Slow timebase; toggles land on fast falling edges.
    initial begin
        forever begin
            #(CLK_PERIOD*SLOW_HALF);
            slow = ~slow;
            if (slow) rises++;
        end
    end

    always @(posedge clk) cyc++;

    task automatic chk(string req, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic quiet();
        @(negedge slow);
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_sleep();
        sleep_cmd = 1;
        @(negedge clk);
        sleep_cmd = 0;
    endtask

    task automatic set_len(logic [22:0] l);
        {len_hi, len_mid, len_lo} = l;
    endtask

    task automatic finish_run();
        if (timed_out) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_LIMIT);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        wait (cyc >= WD_LIMIT);
        timed_out = 1;
        finish_run();
    end

    initial begin
        int e0, e1, e2, t0, r0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10: reset state
        chk("R10 pd_flag", pd_flag, 0);
        chk("R10 fast_clk_en", fast_clk_en, 1);
        chk("R10 status", ec_status, 0);
        chk("R10 irq", ec_irq, 0);
        chk("R10 ts", ts_count, 0);

        // Table walk: R1 entry, R2 length, R3 warm-up
        for (int i = 0; i < NVEC; i++) begin
            logic [22:0] l = VEC[i][26:4];
            logic [3:0]  w = VEC[i][3:0];
            set_len(l);
            warm_len = w;
            quiet();
            e0 = rises;
            pulse_sleep();
            chk("R1 pd_flag on entry", pd_flag, 1);
            chk("R1 clk_en off on entry", fast_clk_en, 0);
            while (!fast_clk_en) @(negedge clk);
            e1 = rises;
            chk("R2 sleep edges", e1 - e0, (l == 0) ? 1 : l);
            while (pd_flag) @(negedge clk);
            e2 = rises;
            chk("R3 warm edges", e2 - e1, w);
            @(negedge clk);
            chk("R3 wake status bit4", ec_status[4], 1);
            ec_ack = 8'hFF; @(negedge clk); ec_ack = 0;
        end

        // R7: host request, irq, acknowledge
        @(negedge clk);
        host_req_wr = 1; @(negedge clk); host_req_wr = 0;
        chk("R7 status bit5", ec_status[5], 1);
        chk("R7 irq", ec_irq, 1);
        ec_ack = 8'h20; @(negedge clk); ec_ack = 0;
        chk("R7 cleared", ec_status, 0);
        chk("R7 irq low", ec_irq, 0);

        // R4: disable blocks entry
        dis_pd = 1;
        @(negedge clk);
        pulse_sleep();
        repeat (4) @(negedge clk);
        chk("R4 stays awake", pd_flag, 0);
        dis_pd = 0;

        // R8 and R5: restriction then forced exit
        set_len(23'd40);
        warm_len = 4'd3;
        quiet();
        pulse_sleep();
        restrict_mode = 1; @(negedge clk);
        chk("R8 lock while asleep", reg_lock, 1);
        restrict_mode = 0; @(negedge clk);
        chk("R8 no lock in other mode", reg_lock, 0);
        dis_pd = 1;
        repeat (3) @(negedge clk);
        chk("R5 exit pd_flag", pd_flag, 0);
        chk("R5 exit clk_en", fast_clk_en, 1);
        repeat (2) @(negedge clk);
        chk("R5 no wake bit", ec_status[4], 0);
        dis_pd = 0;
        @(negedge clk);

        // R6: timestamp tracks slow edges across a sleep
        quiet();
        t0 = ts_count; r0 = rises;
        set_len(23'd4); warm_len = 4'd1;
        pulse_sleep();
        repeat (8) quiet();
        chk("R6 ts delta", ts_count - t0, rises - r0);

        // R9: soft reset mid-sleep keeps timestamp
        set_len(23'd50);
        quiet();
        pulse_sleep();
        host_req_wr = 1; @(negedge clk); host_req_wr = 0;
        t0 = ts_count; r0 = rises;
        soft_rst = 1; @(negedge clk); soft_rst = 0;
        @(negedge clk);
        chk("R9 awake", pd_flag, 0);
        chk("R9 status cleared", ec_status, 0);
        chk("R9 ts kept", ts_count - t0, rises - r0);

        // R6: only hard reset clears timestamp
        quiet();
        rst_n = 0; repeat (2) @(negedge clk); rst_n = 1;
        @(negedge clk);
        chk("R6 hard reset clears ts", ts_count, 0);

        finish_run();
    end
endmodule